// File: doc/BRIEF.md
# I2C Byte Wait and Interrupt Sequencer

This block runs next to an I2C byte shifter and decides, byte by byte, when software must be told that a byte boundary has been reached. It does this with an interrupt pulse. It also decides when the serial clock must be stretched by holding SCL low until software has reacted. It counts SCL falling edges inside each byte, treating the first byte after a start condition as the address byte. For data bytes, a timing-select input moves the interrupt and the wait to either the 8th or the 9th falling edge.

In slave operation, the address byte is classified against the programmed own address. A matching address forces an ACK and stops at the 9th edge. A 10-bit extension prefix stops at the 8th edge. A foreign address after a repeated start only reports at the 9th edge. Any other foreign address leaves the block silent for the rest of the transfer. A wait ends on the first accepted software action: a transmit write, an explicit release, or a start or stop request when acting as master. A transmit write that comes after the wait has already been released is ignored and flagged. A communication release or clearing the enable drops out of the transfer at once.

Top module: `i2c_wait_ctl`

## Requirements
- R1: Each start or stop detection returns the per-byte falling-edge count to zero, and the first byte after a start is the address byte; a start in the middle of a byte therefore delays the next address interrupt to the 9th falling edge after it.
- R2: On a data byte of a transfer the block takes part in, the interrupt and the wait fall on the 8th falling edge when `wait_on_9th` is 0 and on the 9th when it is 1.
- R3: On the address byte, a master, and a slave whose received bits [7:1] equal `own_addr`, raise the interrupt and the wait on the 9th falling edge whatever `wait_on_9th` is.
- R4: A matching slave drives `ack_drive` from its 8th to its 9th address falling edge even when `ack_en` is 0; on data bytes a slave drives it in that window only when `ack_en` is 1.
- R5: A slave that receives an address with bits [7:3] equal to 11110 raises the interrupt and the wait on the 8th falling edge and takes part in the following data bytes.
- R6: A slave whose address does not match after a repeated start (a start while `busy`) raises the interrupt on the 9th falling edge without entering a wait.
- R7: A slave whose address neither matches nor is an extension prefix, outside a repeated start, raises no interrupt and no wait on that address byte or on the following data bytes.
- R8: While `scl_hold` is 1, `sw_write` or `sw_release` in any mode, and `sw_start` or `sw_stop` in master mode only, release the wait: `scl_hold` is 0 one clock later; `sw_start` and `sw_stop` in slave mode leave it held.
- R9: Only the first cancel action of a wait is honoured; an `sw_write` after the wait was released leaves `scl_hold` at 0 and raises a one-cycle `late_write_err` on the next clock.
- R10: `sw_comm_release`, or `if_enable` low, clears `scl_hold`, `busy` and `ack_drive` on the next clock and makes the block ignore the bus until the next start.
- R11: `scl_hold` and `irq` become 1 on the clock that registers the qualifying falling edge, and `irq` lasts exactly one cycle.
- R12: `busy` is 0 after reset, becomes 1 on a start detection and returns to 0 on a stop detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_fall | input | 1 | One-cycle strobe per SCL falling edge |
| start_det | input | 1 | Start or repeated start detected |
| stop_det | input | 1 | Stop detected |
| rx_byte | input | 8 | Received address byte, valid from the 8th through the 9th falling edge |
| is_master | input | 1 | 1 when the local node is bus master |
| wait_on_9th | input | 1 | Data-byte timing select: 0 = 8th edge, 1 = 9th edge |
| ack_en | input | 1 | Acknowledge enable for received data |
| own_addr | input | 7 | Programmed slave address |
| if_enable | input | 1 | Interface enable, level |
| sw_write | input | 1 | Software wrote a transmit byte (strobe) |
| sw_release | input | 1 | Software wait-release strobe |
| sw_start | input | 1 | Software start/restart request strobe |
| sw_stop | input | 1 | Software stop request strobe |
| sw_comm_release | input | 1 | Software communication-release strobe |
| scl_hold | output | 1 | Hold SCL low (wait state) |
| irq | output | 1 | One-cycle transfer interrupt |
| ack_drive | output | 1 | Request to drive ACK on SDA |
| busy | output | 1 | A transfer is in progress |
| late_write_err | output | 1 | Pulse: transmit write after the wait was already released |

## Verification
On every cycle, the assertions check the single-cycle width of the interrupt and the fact that a wait or an ACK request exists only inside a transfer. They also check that an explicit release or a master start/stop ends a wait one clock later, that a slave start request leaves the wait in place, and that an abort clears the hold and busy state. Only the bench's scenarios can show at which falling edge each kind of byte reports. The cases it covers are addressed slave, extension prefix, master, foreign address with and without a repeated start, and both timing-select values. The scenarios also show the forced address ACK, the late-write flag and the mid-byte start.

// File: rtl/i2c_wait_pkg.sv
package i2c_wait_pkg;
    localparam int BYTE_BITS      = 8;
    localparam int ADDR_BITS      = BYTE_BITS - 1;
    localparam int EDGES_PER_BYTE = BYTE_BITS + 1;
    localparam int CNT_W          = $clog2(EDGES_PER_BYTE + 1);
    localparam int EXT_W          = 5;
    localparam logic [EXT_W-1:0] EXT_PREFIX = 5'b11110;

    typedef logic [CNT_W-1:0] edge_t;

    typedef enum logic [1:0] {
        ADR_OTHER = 2'd0,
        ADR_OWN   = 2'd1,
        ADR_EXT   = 2'd2
    } adr_kind_e;

    typedef struct packed {
        logic irq;
        logic hold;
        logic ack_on;
        logic engage;
        logic drop;
    } byte_evt_t;

    function automatic adr_kind_e classify_adr(
        input logic [BYTE_BITS-1:0] b,
        input logic [ADDR_BITS-1:0] own
    );
        if (b[BYTE_BITS-1 -: EXT_W] == EXT_PREFIX)
            return ADR_EXT;
        else if (b[BYTE_BITS-1:1] == own)
            return ADR_OWN;
        else
            return ADR_OTHER;
    endfunction
endpackage

// File: rtl/i2c_wait_edge_cnt.sv
module i2c_wait_edge_cnt
    import i2c_wait_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  fall,
    output edge_t edge_no
);
    localparam edge_t LAST = edge_t'(EDGES_PER_BYTE);

    edge_t cnt;

    assign edge_no = cnt + edge_t'(1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (fall)
            cnt <= (edge_no == LAST) ? '0 : edge_no;
    end
endmodule

// File: rtl/i2c_wait_decode.sv
module i2c_wait_decode
    import i2c_wait_pkg::*;
(
    input  logic      fall,
    input  edge_t     edge_no,
    input  logic      addr_phase,
    input  logic      is_master,
    input  logic      restart,
    input  logic      engaged,
    input  logic      wait_on_9th,
    input  logic      ack_en,
    input  adr_kind_e kind,
    output byte_evt_t evt
);
    localparam edge_t E_DATA = edge_t'(BYTE_BITS);
    localparam edge_t E_ACK  = edge_t'(EDGES_PER_BYTE);

    edge_t data_edge;
    assign data_edge = wait_on_9th ? E_ACK : E_DATA;

    always_comb begin
        evt = '0;
        if (fall) begin
            if (addr_phase) begin
                if (is_master) begin
                    if (edge_no == E_ACK) begin
                        evt.irq    = 1'b1;
                        evt.hold   = 1'b1;
                        evt.engage = 1'b1;
                    end
                end else begin
                    unique case (kind)
                        ADR_OWN: begin
                            if (edge_no == E_DATA)
                                evt.ack_on = 1'b1;
                            if (edge_no == E_ACK) begin
                                evt.irq    = 1'b1;
                                evt.hold   = 1'b1;
                                evt.engage = 1'b1;
                            end
                        end
                        ADR_EXT: begin
                            if (edge_no == E_DATA) begin
                                evt.irq    = 1'b1;
                                evt.hold   = 1'b1;
                                evt.engage = 1'b1;
                            end
                        end
                        default: begin
                            if (edge_no == E_ACK) begin
                                evt.drop = 1'b1;
                                evt.irq  = restart;
                            end
                        end
                    endcase
                end
            end else if (engaged) begin
                if (edge_no == data_edge) begin
                    evt.irq  = 1'b1;
                    evt.hold = 1'b1;
                end
                if (edge_no == E_DATA && ack_en && !is_master)
                    evt.ack_on = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_wait_release.sv
module i2c_wait_release (
    input  logic hold,
    input  logic released,
    input  logic is_master,
    input  logic sw_write,
    input  logic sw_release,
    input  logic sw_start,
    input  logic sw_stop,
    output logic cancel,
    output logic late
);
    logic master_req;

    assign master_req = is_master && (sw_start || sw_stop);
    assign cancel     = hold && (sw_write || sw_release || master_req);
    assign late       = !hold && released && sw_write;
endmodule

// File: rtl/i2c_wait_ctl.sv
module i2c_wait_ctl
    import i2c_wait_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic [BYTE_BITS-1:0] rx_byte,
    input  logic                 is_master,
    input  logic                 wait_on_9th,
    input  logic                 ack_en,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 if_enable,
    input  logic                 sw_write,
    input  logic                 sw_release,
    input  logic                 sw_start,
    input  logic                 sw_stop,
    input  logic                 sw_comm_release,
    output logic                 scl_hold,
    output logic                 irq,
    output logic                 ack_drive,
    output logic                 busy,
    output logic                 late_write_err
);
    localparam edge_t E_ACK = edge_t'(EDGES_PER_BYTE);

    logic      abort;
    logic      frame_clr;
    logic      live_fall;
    edge_t     edge_no;
    adr_kind_e kind;
    byte_evt_t evt;
    logic      cancel;
    logic      late;

    logic addr_phase;
    logic restart_f;
    logic engaged;
    logic released;

    assign abort     = sw_comm_release || !if_enable;
    assign frame_clr = abort || start_det || stop_det;
    assign live_fall = scl_fall && busy && !start_det && !stop_det && !abort;
    assign kind      = classify_adr(rx_byte, own_addr);

    i2c_wait_edge_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_clr),
        .fall    (live_fall),
        .edge_no (edge_no)
    );

    i2c_wait_decode u_dec (
        .fall        (live_fall),
        .edge_no     (edge_no),
        .addr_phase  (addr_phase),
        .is_master   (is_master),
        .restart     (restart_f),
        .engaged     (engaged),
        .wait_on_9th (wait_on_9th),
        .ack_en      (ack_en),
        .kind        (kind),
        .evt         (evt)
    );

    i2c_wait_release u_rel (
        .hold       (scl_hold),
        .released   (released),
        .is_master  (is_master),
        .sw_write   (sw_write),
        .sw_release (sw_release),
        .sw_start   (sw_start),
        .sw_stop    (sw_stop),
        .cancel     (cancel),
        .late       (late)
    );

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy           <= 1'b0;
            addr_phase     <= 1'b0;
            restart_f      <= 1'b0;
            engaged        <= 1'b0;
            released       <= 1'b0;
            scl_hold       <= 1'b0;
            irq            <= 1'b0;
            ack_drive      <= 1'b0;
            late_write_err <= 1'b0;
        end else begin
            irq            <= evt.irq;
            late_write_err <= late;

            if (start_det) begin
                busy       <= 1'b1;
                addr_phase <= 1'b1;
                restart_f  <= busy;
                engaged    <= 1'b0;
                ack_drive  <= 1'b0;
            end else if (stop_det) begin
                busy       <= 1'b0;
                addr_phase <= 1'b0;
                restart_f  <= 1'b0;
                engaged    <= 1'b0;
                ack_drive  <= 1'b0;
            end else begin
                if (live_fall && edge_no == E_ACK) begin
                    addr_phase <= 1'b0;
                    ack_drive  <= 1'b0;
                end
                if (evt.ack_on)
                    ack_drive <= 1'b1;
                if (evt.engage)
                    engaged <= 1'b1;
                else if (evt.drop)
                    engaged <= 1'b0;
            end

            if (evt.hold) begin
                scl_hold <= 1'b1;
                released <= 1'b0;
            end else if (cancel) begin
                scl_hold <= 1'b0;
                released <= 1'b1;
            end else if (start_det || stop_det) begin
                released <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_wait_ctl_chk.sv
module i2c_wait_ctl_chk (
    input logic clk,
    input logic rst,
    input logic scl_fall,
    input logic is_master,
    input logic if_enable,
    input logic sw_write,
    input logic sw_release,
    input logic sw_start,
    input logic sw_stop,
    input logic sw_comm_release,
    input logic scl_hold,
    input logic irq,
    input logic ack_drive,
    input logic busy,
    input logic late_write_err
);
    logic quiet;
    assign quiet = if_enable && !sw_comm_release && !scl_fall;

    // R11
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R10
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_comm_release || !if_enable) |=> (!scl_hold && !busy && !ack_drive));

    // R8
    release_drops_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_hold && quiet && (sw_release || sw_write)) |=> !scl_hold);

    // R8
    master_req_drops_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_hold && quiet && is_master && (sw_start || sw_stop)) |=> !scl_hold);

    // R8
    slave_req_keeps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_hold && quiet && !is_master && !sw_write && !sw_release) |=> scl_hold);

    // R9
    late_write_source_chk: assert property (@(posedge clk) disable iff (rst)
        late_write_err |-> ($past(sw_write) && !$past(scl_hold)));

    // R12
    hold_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_hold || ack_drive) |-> busy);
endmodule

bind i2c_wait_ctl i2c_wait_ctl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .scl_fall        (scl_fall),
    .is_master       (is_master),
    .if_enable       (if_enable),
    .sw_write        (sw_write),
    .sw_release      (sw_release),
    .sw_start        (sw_start),
    .sw_stop         (sw_stop),
    .sw_comm_release (sw_comm_release),
    .scl_hold        (scl_hold),
    .irq             (irq),
    .ack_drive       (ack_drive),
    .busy            (busy),
    .late_write_err  (late_write_err)
);

// File: tb/tb_i2c_wait_ctl.sv
module tb_i2c_wait_ctl;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] OWN = 7'h2A;

    typedef struct packed {
        logic       master;
        logic       sel9;
        logic [7:0] abyte;
        logic [3:0] a_edge;
        logic       a_wait;
        logic [3:0] d_edge;
        logic       d_wait;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'h54, 4'd9, 1'b1, 4'd8, 1'b1},
        '{1'b0, 1'b1, 8'h54, 4'd9, 1'b1, 4'd9, 1'b1},
        '{1'b1, 1'b0, 8'h20, 4'd9, 1'b1, 4'd8, 1'b1},
        '{1'b1, 1'b1, 8'h20, 4'd9, 1'b1, 4'd9, 1'b1},
        '{1'b0, 1'b1, 8'hF0, 4'd8, 1'b1, 4'd9, 1'b1},
        '{1'b0, 1'b0, 8'h20, 4'd0, 1'b0, 4'd0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_fall = 0, start_det = 0, stop_det = 0;
    logic [7:0] rx_byte = 8'h00;
    logic is_master = 0, wait_on_9th = 0, ack_en = 0;
    logic [6:0] own_addr = OWN;
    logic if_enable = 1;
    logic sw_write = 0, sw_release = 0, sw_start = 0, sw_stop = 0, sw_comm_release = 0;
    logic scl_hold, irq, ack_drive, busy, late_write_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_wait_ctl dut (
        .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rx_byte(rx_byte), .is_master(is_master),
        .wait_on_9th(wait_on_9th), .ack_en(ack_en), .own_addr(own_addr),
        .if_enable(if_enable), .sw_write(sw_write), .sw_release(sw_release),
        .sw_start(sw_start), .sw_stop(sw_stop), .sw_comm_release(sw_comm_release),
        .scl_hold(scl_hold), .irq(irq), .ack_drive(ack_drive), .busy(busy),
        .late_write_err(late_write_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fall1();
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask

    task automatic falls(input int n);
        for (int i = 0; i < n; i++) fall1();
    endtask

    task automatic do_start();
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
    endtask

    task automatic do_release();
        @(negedge clk) sw_release = 1'b1;
        @(negedge clk) sw_release = 1'b0;
    endtask

    // nine falling edges; records first edge with irq and whether a wait occurred
    task automatic run_byte(output int irq_e, output int waited);
        irq_e = 0;
        waited = 0;
        for (int e = 1; e <= 9; e++) begin
            fall1();
            if (irq && irq_e == 0) irq_e = e;
            if (scl_hold) begin
                waited = 1;
                do_release();
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ie, wt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "busy after reset", busy, 0);
        chk("R11", "hold/irq after reset", {scl_hold, irq, ack_drive, late_write_err}, 0);

        // table of byte-timing vectors: R2 R3 R5 R7
        for (int v = 0; v < NV; v++) begin
            is_master   = VEC[v].master;
            wait_on_9th = VEC[v].sel9;
            rx_byte     = VEC[v].abyte;
            ack_en      = 1'b1;
            do_start();
            chk("R12", "busy after start", busy, 1);
            run_byte(ie, wt);
            chk("R3", $sformatf("vec%0d address irq edge", v), ie, int'(VEC[v].a_edge));
            chk("R5", $sformatf("vec%0d address wait", v), wt, int'(VEC[v].a_wait));
            run_byte(ie, wt);
            chk("R2", $sformatf("vec%0d data irq edge", v), ie, int'(VEC[v].d_edge));
            chk("R7", $sformatf("vec%0d data wait", v), wt, int'(VEC[v].d_wait));
            do_stop();
            chk("R12", "busy after stop", busy, 0);
        end

        // R4: forced ACK on address match with ack_en = 0
        is_master = 0; wait_on_9th = 1; ack_en = 0; rx_byte = 8'h55;
        do_start();
        falls(8);
        chk("R4", "ack forced on match", ack_drive, 1);
        fall1();
        chk("R4", "ack dropped at 9th", ack_drive, 0);
        chk("R11", "hold on 9th address edge", scl_hold, 1);
        chk("R11", "irq on 9th address edge", irq, 1);
        @(negedge clk);
        chk("R11", "irq one cycle", irq, 0);
        do_release();
        falls(8);
        chk("R4", "no data ack with ack_en 0", ack_drive, 0);
        fall1();
        do_release();
        ack_en = 1;
        falls(8);
        chk("R4", "data ack with ack_en 1", ack_drive, 1);
        fall1();
        do_release();

        // R6: restart with foreign address -> irq at 9, no wait
        rx_byte = 8'h20;
        do_start();
        run_byte(ie, wt);
        chk("R6", "restart mismatch irq edge", ie, 9);
        chk("R6", "restart mismatch wait", wt, 0);
        run_byte(ie, wt);
        chk("R7", "data after mismatch irq", ie, 0);
        do_stop();

        // R1: start in the middle of a byte restarts the count
        is_master = 1; rx_byte = 8'h20;
        do_start();
        falls(5);
        do_start();
        run_byte(ie, wt);
        chk("R1", "address irq after mid-byte start", ie, 9);
        do_stop();

        // R8: master stop request releases wait
        do_start();
        falls(9);
        chk("R8", "master wait entered", scl_hold, 1);
        @(negedge clk) sw_stop = 1'b1;
        @(negedge clk) sw_stop = 1'b0;
        chk("R8", "master sw_stop releases", scl_hold, 0);
        do_stop();

        // R8: slave start request ignored, write releases; R9 late write
        is_master = 0; rx_byte = 8'h54;
        do_start();
        falls(9);
        chk("R8", "slave wait entered", scl_hold, 1);
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
        chk("R8", "slave sw_start ignored", scl_hold, 1);
        @(negedge clk) sw_write = 1'b1;
        @(negedge clk) sw_write = 1'b0;
        chk("R8", "write releases", scl_hold, 0);
        chk("R9", "first write not flagged", late_write_err, 0);
        @(negedge clk) sw_write = 1'b1;
        @(negedge clk) sw_write = 1'b0;
        chk("R9", "late write flagged", late_write_err, 1);
        chk("R9", "late write leaves hold", scl_hold, 0);
        @(negedge clk);
        chk("R9", "late flag one cycle", late_write_err, 0);

        // R10: communication release while waiting
        wait_on_9th = 0;
        falls(8);
        chk("R10", "data wait entered", scl_hold, 1);
        @(negedge clk) sw_comm_release = 1'b1;
        @(negedge clk) sw_comm_release = 1'b0;
        chk("R10", "comm release hold", scl_hold, 0);
        chk("R10", "comm release busy", busy, 0);
        falls(9);
        chk("R10", "bus ignored after release", {scl_hold, irq}, 0);

        // R10: interface disable while waiting
        do_start();
        falls(9);
        chk("R10", "wait before disable", scl_hold, 1);
        @(negedge clk) if_enable = 1'b0;
        @(negedge clk);
        chk("R10", "disable hold", scl_hold, 0);
        chk("R10", "disable busy", busy, 0);
        if_enable = 1'b1;

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule